// File: doc/BRIEF.md
# Delta-Sigma Converter Serial Readout Controller

This block runs the host side of one framed serial exchange with a multi-channel delta-sigma converter. The converter's multiplexer and its result port share one chip select and one serial clock. A request names a channel with an enable bit and a 3-bit address. The controller pulls the select low and toggles the serial clock 24 times. During the first four rising edges it sends the channel word to the converter. On every rising edge it captures one bit of the converter's 24-bit result. The selected channel therefore takes effect in the same frame that reads out the previous conversion.

After the last falling edge the controller releases the select and decodes the captured word. The word holds a ready flag (0 means fresh data), a filler bit, a sign bit (1 means positive), an extended-range bit and a 20-bit magnitude. The controller turns these into a signed 25-bit code in LSB units, and it flags the two clamp codes the converter emits at +9/8 and -1/8 of full scale. A word whose ready flag is 1 does not produce a result strobe, and the previous result stays on the outputs.

The serial clock rate is the system clock divided by 2·`DIV_HALF`. The mux select line of the converter is taken as the inverse of `adc_cs_n` outside this block.

Top module: `adc_readout_ctrl`

## Requirements
- R1: While reset is high, and after it, the controller is idle: `adc_cs_n`=1, `adc_sck`=0, `adc_mosi`=0, `busy`=0, `res_valid`=0, `res_code`=0, `res_over`=0, `res_under`=0.
- R2: A `req_valid` seen while idle pulls `adc_cs_n` low on the next cycle. `adc_sck` then stays low for `DIV_HALF` cycles and makes 24 pulses, each high for `DIV_HALF` cycles and low for `DIV_HALF` cycles. `adc_cs_n` returns high on the cycle of the 24th falling edge. `busy` is high exactly while `adc_cs_n` is low.
- R3: `adc_mosi` carries the channel word most significant bit first: `req_en`, then `req_addr[2]`, `req_addr[1]`, `req_addr[0]`. The first bit appears together with the select and each later bit after a falling edge of `adc_sck`. After the fourth falling edge `adc_mosi` is 0. It never changes on a rising edge.
- R4: `adc_miso` is sampled on each rising edge of `adc_sck`. The first sample is bit 23, and the bits follow in order down to bit 0.
- R5: Bit 23 is the ready flag. When it is 1 no `res_valid` pulse is produced and `res_code`, `res_over` and `res_under` keep their previous values.
- R6: When bit 23 is 0, `res_valid` is high for exactly one cycle, the cycle in which `adc_cs_n` returns high. The new result outputs appear in that same cycle.
- R7: With sign bit 21 = 1, `res_code` = bit20·2^20 + bits[19:0]. Full scale reads 1048575 and one LSB above full scale reads 1048576.
- R8: With sign bit 21 = 0 and a nonzero {bit20, bits[19:0]}, `res_code` = {bit20, bits[19:0]} − 2^21. So {1, all ones} reads −1 and {1, 0xE0000} reads −131072.
- R9: When bit 20 and bits[19:0] are all 0, `res_code` is 0 whichever value the sign bit has.
- R10: `res_over` is 1 exactly when `res_code` ≥ 1179647, the +9/8 clamp code (sign 1, bit20 1, magnitude 0x1FFFF).
- R11: `res_under` is 1 exactly when `res_code` ≤ −131072, the −1/8 clamp code. −131071 does not raise it.
- R12: Bit 22 (the filler bit) has no effect on any result output.
- R13: A `req_valid` that arrives while `busy` is high is ignored. The running frame continues unchanged and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a frame (taken only while idle) |
| req_en | input | 1 | Multiplexer enable bit of the channel word |
| req_addr | input | 3 | Channel address bits of the channel word |
| adc_cs_n | output | 1 | Shared chip select, active low |
| adc_sck | output | 1 | Shared serial clock, idles low |
| adc_mosi | output | 1 | Channel word to the converter |
| adc_miso | input | 1 | Result bits from the converter |
| busy | output | 1 | Frame in progress |
| res_valid | output | 1 | One-cycle strobe for a fresh result |
| res_code | output | 25 | Signed result in LSB units |
| res_over | output | 1 | Positive clamp code seen |
| res_under | output | 1 | Negative clamp code seen |

## Verification
The bench goes after the codes where a plain shift register gives wrong answers. At zero it feeds both sign readings; a decoder that simply extends the sign turns the negative reading into −2^21. It feeds one LSB above full scale, which reads as zero if the extended-range bit is dropped, and minus one LSB, which reads as a large positive number if the sign is taken as two's complement. It also probes the two clamp boundaries, together with codes one LSB inside them, so that an off-by-one in the flag comparisons shows up. A word that is not ready must leave the outputs untouched, and a request that arrives mid-frame must neither restart nor extend the clock train. A filler bit of 1 must not leak into the code. The serial pins are compared against a timeline model on every cycle, so a shifted edge or a channel bit that changes on the rising edge shows up at once.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    localparam int WORD_W  = 24;                    // bits per frame
    localparam int MAG_W   = 20;                    // magnitude field width
    localparam int CHAN_W  = 4;                     // enable + 3 address bits
    localparam int ADDR_W  = CHAN_W - 1;
    localparam int CODE_W  = 25;                    // decoded signed width
    localparam int PAY_W   = MAG_W + 2;             // sign + ext + magnitude
    localparam int PAD_W   = CODE_W - MAG_W - 1;    // replicated sign bits
    localparam int CNT_W   = $clog2(WORD_W + 1);

    // +9/8 clamp: sign 1, ext 1, magnitude 0x1FFFF
    localparam logic [MAG_W-1:0]         OVR_MAG    = MAG_W'(20'h1FFFF);
    // -1/8 clamp in LSB units
    localparam logic signed [CODE_W-1:0] UNDER_CODE = -25'sd131072;

    typedef struct packed {
        logic             sgn;   // 1 = positive
        logic             ext;   // extended-range bit
        logic [MAG_W-1:0] mag;
    } adc_payload_t;

    typedef struct packed {
        logic signed [CODE_W-1:0] code;
        logic                     over;
        logic                     under;
    } adc_res_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW
    } seq_state_e;

    function automatic adc_res_t decode_payload(adc_payload_t p);
        adc_res_t r;
        // positive: {0,ext,mag}; negative: {ext,mag} - 2^21 == sign-extended {1,ext,mag}
        r.code = {{PAD_W{~p.sgn}}, p.ext, p.mag};
        if (!p.ext && (p.mag == '0))
            r.code = '0;                 // both zero readings map to 0
        r.over  = p.sgn & p.ext & (p.mag >= OVR_MAG);
        r.under = ($signed(r.code) <= UNDER_CODE);
        return r;
    endfunction

endpackage

// File: rtl/adc_rd_tick.sv
module adc_rd_tick #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    generate
        if (DIV_HALF <= 1) begin : g_direct
            assign tick = run;
        end else begin : g_count
            localparam int TW = $clog2(DIV_HALF);
            localparam logic [TW-1:0] LAST = TW'(DIV_HALF - 1);
            logic [TW-1:0] cnt;

            assign tick = run && (cnt == LAST);

            always_ff @(posedge clk) begin
                if (rst || !run || tick)
                    cnt <= '0;
                else
                    cnt <= cnt + 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift
    import adc_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CHAN_W-1:0] chan_word,
    input  logic              rise,
    input  logic              fall,
    input  logic              miso,
    output logic              mosi,
    output logic              eoc_bit,
    output adc_payload_t      payload
);
    logic [CHAN_W-1:0] tx_q;
    logic [WORD_W-1:0] rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= '0;
        end else if (load) begin
            tx_q <= chan_word;
        end else if (fall) begin
            tx_q <= {tx_q[CHAN_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rx_q <= '0;
        else if (rise)
            rx_q <= {rx_q[WORD_W-2:0], miso};
    end

    assign mosi    = tx_q[CHAN_W-1];
    assign eoc_bit = rx_q[WORD_W-1];
    assign payload = adc_payload_t'(rx_q[PAY_W-1:0]);
endmodule

// File: rtl/adc_rd_decode.sv
module adc_rd_decode
    import adc_rd_pkg::*;
(
    input  adc_payload_t payload,
    output adc_res_t     res
);
    always_comb begin
        res = decode_payload(payload);
        p_flags_excl_r10: assert (!(res.over && res.under))
            else $error("over and under flags both set");
    end
endmodule

// File: rtl/adc_readout_ctrl.sv
module adc_readout_ctrl
    import adc_rd_pkg::*;
#(
    parameter int DIV_HALF = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic                     req_en,
    input  logic [2:0]               req_addr,
    output logic                     adc_cs_n,
    output logic                     adc_sck,
    output logic                     adc_mosi,
    input  logic                     adc_miso,
    output logic                     busy,
    output logic                     res_valid,
    output logic signed [CODE_W-1:0] res_code,
    output logic                     res_over,
    output logic                     res_under
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W);

    seq_state_e       state;
    logic [CNT_W-1:0] bit_cnt;
    logic             sck_q, cs_n_q, valid_q;
    logic             tick, rise, fall, load;
    logic             eoc_bit;
    adc_payload_t     payload;
    adc_res_t         dec, res_q;

    assign load = (state == ST_IDLE) && req_valid;
    assign rise = ((state == ST_LEAD) || (state == ST_LOW)) && tick;
    assign fall = (state == ST_HIGH) && tick;

    adc_rd_tick #(.DIV_HALF(DIV_HALF)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (state != ST_IDLE),
        .tick (tick)
    );

    adc_rd_shift u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .chan_word ({req_en, req_addr}),
        .rise      (rise),
        .fall      (fall),
        .miso      (adc_miso),
        .mosi      (adc_mosi),
        .eoc_bit   (eoc_bit),
        .payload   (payload)
    );

    adc_rd_decode u_decode (
        .payload (payload),
        .res     (dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            sck_q   <= 1'b0;
            cs_n_q  <= 1'b1;
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        state   <= ST_LEAD;
                        cs_n_q  <= 1'b0;
                        bit_cnt <= '0;
                    end
                end
                ST_LEAD, ST_LOW: begin
                    if (tick) begin
                        sck_q   <= 1'b1;
                        bit_cnt <= bit_cnt + 1'b1;
                        state   <= ST_HIGH;
                    end
                end
                ST_HIGH: begin
                    if (tick) begin
                        sck_q <= 1'b0;
                        if (bit_cnt == LAST_BIT) begin
                            state   <= ST_IDLE;
                            cs_n_q  <= 1'b1;
                            valid_q <= ~eoc_bit;
                            if (!eoc_bit)
                                res_q <= dec;
                        end else begin
                            state <= ST_LOW;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign adc_cs_n  = cs_n_q;
    assign adc_sck   = sck_q;
    assign busy      = (state != ST_IDLE);
    assign res_valid = valid_q;
    assign res_code  = res_q.code;
    assign res_over  = res_q.over;
    assign res_under = res_q.under;

    // clock pulses only inside a frame
    p_sck_framed_r2: assert property (@(posedge clk) disable iff (rst)
        adc_sck |-> !adc_cs_n);
    // rise count never passes the word length
    p_bits_bounded_r2: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= LAST_BIT);
    // data to the converter holds across the rising edge
    p_mosi_hold_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_sck) |-> $stable(adc_mosi));
    // strobe lasts one cycle
    p_strobe_single_r6: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);
    // strobe coincides with the select release
    p_strobe_at_end_r6: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $rose(adc_cs_n));
    // over flag only with a positive code
    p_over_positive_r10: assert property (@(posedge clk) disable iff (rst)
        res_over |-> (res_code > 0));
    // under flag only with a negative code
    p_under_negative_r11: assert property (@(posedge clk) disable iff (rst)
        res_under |-> (res_code < 0));
    // no new frame opens while one runs
    p_no_restart_r13: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> !$fell(adc_cs_n));
endmodule

// File: tb/adc_readout_ctrl_test.sv
`timescale 1ns/1ps
module adc_readout_ctrl_test;
    localparam int D = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic        req_valid = 1'b0;
    logic        req_en    = 1'b0;
    logic [2:0]  req_addr  = 3'd0;
    logic        adc_miso  = 1'b0;
    logic        adc_cs_n, adc_sck, adc_mosi, busy, res_valid, res_over, res_under;
    logic signed [24:0] res_code;

    adc_readout_ctrl #(.DIV_HALF(D)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_en(req_en),
        .req_addr(req_addr), .adc_cs_n(adc_cs_n), .adc_sck(adc_sck),
        .adc_mosi(adc_mosi), .adc_miso(adc_miso), .busy(busy),
        .res_valid(res_valid), .res_code(res_code), .res_over(res_over),
        .res_under(res_under)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    finished = 0;
    string tag      = "R1";

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [23:0] word_q[$];
    logic [23:0] cur_word = '0;
    logic [3:0]  chan = '0;
    bit     in_frame = 0;
    int     n = 0, falls = 0;
    bit     ex_cs_n = 1, ex_sck = 0, ex_mosi = 0, ex_busy = 0, ex_valid = 0;
    bit     ex_over = 0, ex_under = 0;
    longint ex_code = 0;

    task automatic expect_decode(input logic [23:0] w);
        longint mag;
        mag = longint'(w[20]) * (64'sd1 << 20) + longint'(w[19:0]);
        if (w[20] == 1'b0 && w[19:0] == 20'd0) ex_code = 0;            // R9
        else if (w[21])                        ex_code = mag;          // R7
        else                                   ex_code = mag - (64'sd1 << 21); // R8
        ex_over  = (ex_code >= 1179647);                                // R10
        ex_under = (ex_code <= -131072);                                // R11
    endtask

    always @(posedge clk) begin
        if (rst) begin
            in_frame = 0; ex_cs_n = 1; ex_sck = 0; ex_mosi = 0; ex_busy = 0;
            ex_valid = 0; ex_code = 0; ex_over = 0; ex_under = 0; falls = 0;
        end else begin
            ex_valid = 0;
            if (!in_frame) begin
                if (req_valid) begin
                    in_frame = 1; n = 0; falls = 0;
                    chan = {req_en, req_addr};
                    cur_word = (word_q.size() > 0) ? word_q.pop_front() : 24'd0;
                    ex_cs_n = 0; ex_busy = 1; ex_mosi = chan[3];
                end
            end else begin   // requests here are ignored (R13)
                n++;
                if (n % (2*D) == D) begin
                    ex_sck = 1;
                end else if (n % (2*D) == 0) begin
                    ex_sck = 0;
                    falls++;
                    ex_mosi = (falls < 4) ? chan[3-falls] : 1'b0;
                    if (falls == 24) begin
                        in_frame = 0; ex_cs_n = 1; ex_busy = 0;
                        if (!cur_word[23]) begin       // R5 / R6
                            ex_valid = 1;
                            expect_decode(cur_word);
                        end
                    end
                end
            end
        end
    end

    // converter model and per-cycle comparison
    always @(negedge clk) begin
        if (!rst && !finished) begin
            check(adc_cs_n == ex_cs_n, "R2", "cs_n", adc_cs_n, ex_cs_n);
            check(adc_sck  == ex_sck,  "R2", "sck",  adc_sck,  ex_sck);
            check(busy     == ex_busy, "R2", "busy", busy,     ex_busy);
            check(adc_mosi == ex_mosi, "R3", "mosi", adc_mosi, ex_mosi);
            check(res_valid == ex_valid, (ex_valid ? "R6" : "R5"), "res_valid", res_valid, ex_valid);
            check(longint'(res_code) == ex_code, tag, "res_code", longint'(res_code), ex_code);
            check(res_over  == ex_over,  tag, "res_over",  res_over,  ex_over);
            check(res_under == ex_under, tag, "res_under", res_under, ex_under);
        end
        // R4: bit 23 first, one new bit after each falling edge
        adc_miso <= (in_frame && falls < 24) ? cur_word[23-falls] : 1'b0;
    end

    function automatic logic [23:0] mk(input bit eoc, input bit dmy, input bit s,
                                       input bit x, input logic [19:0] m);
        return {eoc, dmy, s, x, m};
    endfunction

    task automatic frame(input bit en, input logic [2:0] addr,
                         input logic [23:0] w, input string t);
        word_q.push_back(w);
        @(negedge clk);
        tag = t;
        req_valid = 1'b1; req_en = en; req_addr = addr;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (48*D + 3) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(adc_cs_n == 1'b1, "R1", "cs_n in reset", adc_cs_n, 1);
        check(adc_sck == 1'b0 && adc_mosi == 1'b0, "R1", "sck|mosi in reset", {adc_sck, adc_mosi}, 0);
        check(busy == 1'b0 && res_valid == 1'b0, "R1", "busy|valid in reset", {busy, res_valid}, 0);
        check(res_code == 0 && !res_over && !res_under, "R1", "result in reset", longint'(res_code), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        frame(1'b1, 3'b101, mk(0,0,1,0,20'hFFFFF), "R7");   // full scale
        frame(1'b1, 3'b010, mk(0,0,1,1,20'h00000), "R7");   // +1 LSB above full scale
        frame(1'b0, 3'b111, mk(0,0,1,1,20'h1FFFF), "R10");  // +9/8 clamp
        frame(1'b1, 3'b001, mk(0,0,1,1,20'h1FFFE), "R10");  // one below clamp
        frame(1'b1, 3'b110, mk(0,0,1,0,20'h00000), "R9");   // zero, sign 1
        frame(1'b1, 3'b011, mk(0,0,0,0,20'h00000), "R9");   // zero, sign 0
        frame(1'b1, 3'b100, mk(0,0,0,1,20'hFFFFF), "R8");   // -1 LSB
        frame(1'b0, 3'b000, mk(0,0,0,1,20'hE0000), "R11");  // -1/8 clamp
        frame(1'b1, 3'b101, mk(0,0,0,1,20'hE0001), "R11");  // just inside
        frame(1'b1, 3'b010, mk(1,0,1,0,20'h12345), "R5");   // not ready: hold
        frame(1'b1, 3'b111, mk(0,1,1,0,20'h80000), "R12");  // filler bit set

        // R13: request during a running frame is ignored
        word_q.push_back(mk(0,0,0,1,20'hABCDE));
        @(negedge clk);
        tag = "R13";
        req_valid = 1'b1; req_en = 1'b1; req_addr = 3'b011;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (20) @(negedge clk);
        req_valid = 1'b1; req_en = 1'b0; req_addr = 3'b100;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (48*D + 10) @(negedge clk);
        check(word_q.size() == 0 && busy == 1'b0, "R13", "idle after ignored request", busy, 0);

        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "WATCHDOG", "run did not end", 0, 1);
        finish_run();
    end
endmodule